// File: doc/BRIEF.md
# Entropy Reseed and Secret-Wipe Sequencer

This block schedules two housekeeping actions for a cipher engine. The first is reloading the seed of its internal masking/wiping PRNG from an external entropy source. The second is overwriting the key, IV and data registers with pseudo-random values.

After reset it always fetches fresh entropy first, then wipes every secret register, and only then reports idle. During operation, several events queue a reseed:

- a new key, when the key-reseed policy bit is set;
- a block counter reaching a programmable limit;
- a software trigger;
- a write of the control register.

Two further software triggers queue a wipe of the input side (key, IV, input data) or of the output data.

The entropy port is a request/acknowledge pair. The request stays high and holds the sequencer in its reseed step until the source acknowledges. The source therefore applies back-pressure simply by withholding the acknowledge. An acknowledge with no request open is ignored. On the acknowledge cycle the block strobes a seed-load pulse to the PRNG.

Every trigger is latched as a pending flag, visible on an output, and drops when its action begins. Triggers that arrive while the sequencer is busy wait their turn. A reseed always goes before a wipe. A fault input sends the sequencer into a terminal state that raises a fatal alert, blocks data release and ends all activity until the next reset.

Top module: `reseed_clear_seq`

## Requirements
- R1: After reset deasserts, `ent_req_o` is 1 and `idle_o` is 0 with no wipe active. The acknowledge cycle pulses `prng_seed_o`. Then `clr_in_o` and `clr_out_o` are both 1 for exactly CLR_CYC cycles, after which `idle_o` is 1.
- R2: `ent_req_o` remains 1 until a cycle with `ent_ack_i` = 1. `ent_ack_i` while no request is open produces no `prng_seed_o` and leaves `idle_o` unchanged.
- R3: A `key_new_i` pulse queues a reseed when `cfg_key_reseed_i` = 1. When `cfg_key_reseed_i` = 0 it has no effect: `idle_o` stays 1 and `trig_reseed_o` stays 0.
- R4: Each `blk_done_i` pulse advances a block counter. The limit is set by `cfg_rate_i`: 0 selects RATE0, 1 selects RATE1, and 2 or 3 select RATE2. The pulse that reaches the limit queues a reseed. Any reseed that begins zeroes the counter.
- R5: A `trig_reseed_i` pulse and a `cfg_wr_i` pulse each queue a reseed. In the cycle after such a pulse, `ent_req_o` is 0 and `idle_o` is 0. `ent_req_o` rises one cycle later.
- R6: `trig_clr_in_i` wipes the input side only (`clr_in_o`). `trig_clr_out_i` wipes the output side only (`clr_out_o`). Both together assert both outputs. Each wipe lasts CLR_CYC cycles.
- R7: `trig_reseed_o`, `trig_clr_in_o` and `trig_clr_out_o` show the queued requests and fall when their action starts. A request raised while the sequencer is busy stays queued and is served next. When both are queued, the reseed runs before the wipe.
- R8: A `fault_i` pulse sets `fatal_o` to 1 and `out_allow_o` to 0 from the next cycle onward, until reset. While in this state, `ent_req_o`, `clr_in_o`, `clr_out_o` and `idle_o` stay 0 whatever the triggers do.
- R9: `idle_o` is 1 only when no reseed or wipe is running or queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ent_req_o | output | 1 | Entropy request, held until acknowledged |
| ent_ack_i | input | 1 | Entropy acknowledge |
| prng_seed_o | output | 1 | Seed-load strobe to the PRNG |
| blk_done_i | input | 1 | One pulse per processed block |
| key_new_i | input | 1 | New key provided pulse |
| cfg_key_reseed_i | input | 1 | Key update forces reseed when 1 |
| cfg_rate_i | input | 2 | Block-count reseed rate select |
| cfg_wr_i | input | 1 | Control register written pulse |
| trig_reseed_i | input | 1 | Software reseed trigger pulse |
| trig_clr_in_i | input | 1 | Software input-side wipe trigger pulse |
| trig_clr_out_i | input | 1 | Software output-side wipe trigger pulse |
| trig_reseed_o | output | 1 | Reseed queued |
| trig_clr_in_o | output | 1 | Input-side wipe queued |
| trig_clr_out_o | output | 1 | Output-side wipe queued |
| clr_in_o | output | 1 | Wipe enable for key, IV and input data |
| clr_out_o | output | 1 | Wipe enable for output data |
| idle_o | output | 1 | Nothing running or queued |
| fault_i | input | 1 | Fault detected pulse |
| fatal_o | output | 1 | Fatal alert, sticky until reset |
| out_allow_o | output | 1 | Data release permitted |

## Verification
The embedded assertions check four things on every cycle:

- the open entropy request holds until acknowledged;
- the fatal state is sticky and silent;
- idle never coincides with a request or a wipe;
- each queued flag falls when taken, and the block counter wraps to zero on a hit.

Only the bench scenarios can show the following:

- the boot order of reseed then wipe, and the exact wipe length;
- the block limit for every rate encoding, and the counter restart after an unrelated reseed;
- the queuing of requests raised mid-sequence, and the reseed-first ordering.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    ST_SEED = 2'd0,
    ST_WIPE = 2'd1,
    ST_IDLE = 2'd2,
    ST_FAIL = 2'd3
  } rsc_state_e;

  localparam int unsigned NUM_TRIG = 3;
  localparam int unsigned TRIG_RSD = 0;
  localparam int unsigned TRIG_CI  = 1;
  localparam int unsigned TRIG_CO  = 2;
endpackage

// File: rtl/rsc_trig_latch.sv
module rsc_trig_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= set_i | (pend_q & ~take_i);
  end

  assign pend_o = pend_q;

  // R7: a taken request with no fresh set is gone next cycle
  a_r7_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !set_i |=> !pend_o);
endmodule

// File: rtl/rsc_blk_ctr.sv
module rsc_blk_ctr #(
  parameter int unsigned RATE0 = 64,
  parameter int unsigned RATE1 = 8192,
  parameter int unsigned RATE2 = 1048576
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       blk_i,
  input  logic [1:0] rate_i,
  input  logic       zero_i,
  output logic       hit_o
);
  localparam int unsigned CW = $clog2(RATE2 + 1);

  logic [CW-1:0] cnt_q, limit;

  always_comb begin
    unique case (rate_i)
      2'd0:    limit = CW'(RATE0);
      2'd1:    limit = CW'(RATE1);
      default: limit = CW'(RATE2);
    endcase
  end

  assign hit_o = blk_i && !zero_i && (cnt_q >= limit - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (zero_i || hit_o) cnt_q <= '0;
    else if (blk_i)          cnt_q <= cnt_q + 1'b1;
  end

  // R4: reaching the limit restarts the count
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_q == '0);
  // R4: a reseed start zeroes the count
  a_r4_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> cnt_q == '0);
endmodule

// File: rtl/rsc_fsm.sv
module rsc_fsm
  import rsc_pkg::*;
#(
  parameter int unsigned CLR_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_rsd_i,
  input  logic pend_ci_i,
  input  logic pend_co_i,
  input  logic ack_i,
  input  logic fault_i,
  output logic req_o,
  output logic seed_o,
  output logic clr_in_o,
  output logic clr_out_o,
  output logic idle_o,
  output logic fatal_o,
  output logic take_rsd_o,
  output logic take_clr_o
);
  localparam int unsigned CCW = (CLR_CYC > 1) ? $clog2(CLR_CYC) : 1;
  localparam logic [CCW-1:0] CC_LAST = CCW'(CLR_CYC - 1);

  rsc_state_e     st_q;
  logic           boot_q, sel_in_q, sel_out_q;
  logic [CCW-1:0] ccnt_q;
  logic           any_clr;

  assign any_clr    = pend_ci_i | pend_co_i;
  assign take_rsd_o = (st_q == ST_IDLE) && pend_rsd_i && !fault_i;
  assign take_clr_o = (st_q == ST_IDLE) && !pend_rsd_i && any_clr && !fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_SEED;
      boot_q    <= 1'b1;
      sel_in_q  <= 1'b0;
      sel_out_q <= 1'b0;
      ccnt_q    <= '0;
    end else if (fault_i) begin
      st_q <= ST_FAIL;
    end else begin
      unique case (st_q)
        ST_SEED: if (ack_i) begin
          if (boot_q) begin
            st_q      <= ST_WIPE;
            boot_q    <= 1'b0;
            sel_in_q  <= 1'b1;
            sel_out_q <= 1'b1;
            ccnt_q    <= '0;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_WIPE: begin
          if (ccnt_q == CC_LAST) st_q <= ST_IDLE;
          else                   ccnt_q <= ccnt_q + 1'b1;
        end
        ST_IDLE: begin
          if (pend_rsd_i) begin
            st_q <= ST_SEED;
          end else if (any_clr) begin
            st_q      <= ST_WIPE;
            sel_in_q  <= pend_ci_i;
            sel_out_q <= pend_co_i;
            ccnt_q    <= '0;
          end
        end
        default: st_q <= ST_FAIL;
      endcase
    end
  end

  assign req_o     = (st_q == ST_SEED);
  assign seed_o    = req_o && ack_i && !fault_i;
  assign clr_in_o  = (st_q == ST_WIPE) && sel_in_q;
  assign clr_out_o = (st_q == ST_WIPE) && sel_out_q;
  assign idle_o    = (st_q == ST_IDLE) && !pend_rsd_i && !any_clr;
  assign fatal_o   = (st_q == ST_FAIL);

  // R2: open request is held until acknowledged
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i && !fault_i |=> req_o);
  // R8: terminal state never exits before reset
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  // R8: terminal state is silent
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !req_o && !clr_in_o && !clr_out_o && !idle_o);
  // R9: idle excludes any running action
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !req_o && !clr_in_o && !clr_out_o);
  // R1: no idle before the boot reseed and wipe have run
  a_r1_boot_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_q |-> !idle_o && !clr_in_o);
endmodule

// File: rtl/reseed_clear_seq.sv
module reseed_clear_seq
  import rsc_pkg::*;
#(
  parameter int unsigned RATE0   = 64,
  parameter int unsigned RATE1   = 8192,
  parameter int unsigned RATE2   = 1048576,
  parameter int unsigned CLR_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       ent_req_o,
  input  logic       ent_ack_i,
  output logic       prng_seed_o,
  input  logic       blk_done_i,
  input  logic       key_new_i,
  input  logic       cfg_key_reseed_i,
  input  logic [1:0] cfg_rate_i,
  input  logic       cfg_wr_i,
  input  logic       trig_reseed_i,
  input  logic       trig_clr_in_i,
  input  logic       trig_clr_out_i,
  output logic       trig_reseed_o,
  output logic       trig_clr_in_o,
  output logic       trig_clr_out_o,
  output logic       clr_in_o,
  output logic       clr_out_o,
  output logic       idle_o,
  input  logic       fault_i,
  output logic       fatal_o,
  output logic       out_allow_o
);
  logic [NUM_TRIG-1:0] set_v, take_v, pend_v;
  logic blk_hit, take_rsd, take_clr;

  rsc_blk_ctr #(.RATE0(RATE0), .RATE1(RATE1), .RATE2(RATE2)) i_blk_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .blk_i  (blk_done_i),
    .rate_i (cfg_rate_i),
    .zero_i (take_rsd),
    .hit_o  (blk_hit)
  );

  assign set_v[TRIG_RSD]  = trig_reseed_i | cfg_wr_i | blk_hit
                          | (key_new_i & cfg_key_reseed_i);
  assign set_v[TRIG_CI]   = trig_clr_in_i;
  assign set_v[TRIG_CO]   = trig_clr_out_i;
  assign take_v[TRIG_RSD] = take_rsd;
  assign take_v[TRIG_CI]  = take_clr;
  assign take_v[TRIG_CO]  = take_clr;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    rsc_trig_latch i_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .take_i (take_v[g]),
      .pend_o (pend_v[g])
    );
  end

  rsc_fsm #(.CLR_CYC(CLR_CYC)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_rsd_i (pend_v[TRIG_RSD]),
    .pend_ci_i  (pend_v[TRIG_CI]),
    .pend_co_i  (pend_v[TRIG_CO]),
    .ack_i      (ent_ack_i),
    .fault_i    (fault_i),
    .req_o      (ent_req_o),
    .seed_o     (prng_seed_o),
    .clr_in_o   (clr_in_o),
    .clr_out_o  (clr_out_o),
    .idle_o     (idle_o),
    .fatal_o    (fatal_o),
    .take_rsd_o (take_rsd),
    .take_clr_o (take_clr)
  );

  assign trig_reseed_o  = pend_v[TRIG_RSD];
  assign trig_clr_in_o  = pend_v[TRIG_CI];
  assign trig_clr_out_o = pend_v[TRIG_CO];
  assign out_allow_o    = ~fatal_o;

  // R8: data release is blocked whenever the alert stands
  a_r8_no_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !out_allow_o);
endmodule

// File: tb/test_reseed_clear_seq.sv
module test_reseed_clear_seq;
  localparam int unsigned R0 = 3, R1 = 5, R2 = 7, CC = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0;
  logic ent_req_o, ent_ack_i = 1'b0, prng_seed_o;
  logic blk_done_i = 1'b0, key_new_i = 1'b0, cfg_key_reseed_i = 1'b0;
  logic [1:0] cfg_rate_i = 2'd0;
  logic cfg_wr_i = 1'b0, trig_reseed_i = 1'b0, trig_clr_in_i = 1'b0, trig_clr_out_i = 1'b0;
  logic trig_reseed_o, trig_clr_in_o, trig_clr_out_o, clr_in_o, clr_out_o, idle_o;
  logic fault_i = 1'b0, fatal_o, out_allow_o;

  reseed_clear_seq #(.RATE0(R0), .RATE1(R1), .RATE2(R2), .CLR_CYC(CC)) i_reseed_clear_seq (
    .clk_i(clk), .rst_ni(rst_ni), .ent_req_o(ent_req_o), .ent_ack_i(ent_ack_i),
    .prng_seed_o(prng_seed_o), .blk_done_i(blk_done_i), .key_new_i(key_new_i),
    .cfg_key_reseed_i(cfg_key_reseed_i), .cfg_rate_i(cfg_rate_i), .cfg_wr_i(cfg_wr_i),
    .trig_reseed_i(trig_reseed_i), .trig_clr_in_i(trig_clr_in_i),
    .trig_clr_out_i(trig_clr_out_i), .trig_reseed_o(trig_reseed_o),
    .trig_clr_in_o(trig_clr_in_o), .trig_clr_out_o(trig_clr_out_o),
    .clr_in_o(clr_in_o), .clr_out_o(clr_out_o), .idle_o(idle_o),
    .fault_i(fault_i), .fatal_o(fatal_o), .out_allow_o(out_allow_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic serve_seed(input string tag);
    chk({tag, " req open"}, ent_req_o, 1);
    ent_ack_i = 1'b1;
    #1;
    chk({tag, " seed strobe"}, prng_seed_o, 1);
    step();
    ent_ack_i = 1'b0;
  endtask

  task automatic expect_reseed(input string tag);
    chk({tag, " queued"}, trig_reseed_o, 1);
    chk({tag, " not idle"}, idle_o, 0);
    chk({tag, " req not yet"}, ent_req_o, 0);
    step();
    chk({tag, " req up"}, ent_req_o, 1);
    chk({tag, " R7 self-clear"}, trig_reseed_o, 0);
    serve_seed(tag);
    chk({tag, " back idle"}, idle_o, 1);
  endtask

  task automatic run_wipe(input string tag, input logic ei, input logic eo);
    for (int i = 0; i < CC; i++) begin
      chk({tag, " clr_in"}, clr_in_o, ei);
      chk({tag, " clr_out"}, clr_out_o, eo);
      step();
    end
    chk({tag, " wipe ended in"}, clr_in_o, 0);
    chk({tag, " wipe ended out"}, clr_out_o, 0);
    chk({tag, " R9 idle after"}, idle_o, 1);
  endtask

  task automatic boot(input string tag);
    rst_ni = 1'b0;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    chk({tag, " req"}, ent_req_o, 1);
    chk({tag, " idle"}, idle_o, 0);
    chk({tag, " no wipe"}, clr_in_o | clr_out_o, 0);
    chk({tag, " no alert"}, fatal_o, 0);
    chk({tag, " release"}, out_allow_o, 1);
    repeat (4) step();
    chk("R2 req held", ent_req_o, 1);
    serve_seed(tag);
    run_wipe(tag, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    // R1 boot order
    boot("R1 boot");

    // R2 stray acknowledge ignored
    ent_ack_i = 1'b1;
    #1;
    chk("R2 stray ack no seed", prng_seed_o, 0);
    step();
    ent_ack_i = 1'b0;
    chk("R2 stray ack idle", idle_o, 1);
    chk("R2 stray ack no req", ent_req_o, 0);

    // R3 key policy
    cfg_key_reseed_i = 1'b0;
    key_new_i = 1'b1; step(); key_new_i = 1'b0;
    chk("R3 policy off idle", idle_o, 1);
    chk("R3 policy off queue", trig_reseed_o, 0);
    cfg_key_reseed_i = 1'b1;
    key_new_i = 1'b1; step(); key_new_i = 1'b0;
    expect_reseed("R3 key");

    // R5 software and control write
    trig_reseed_i = 1'b1; step(); trig_reseed_i = 1'b0;
    expect_reseed("R5 sw");
    cfg_wr_i = 1'b1; step(); cfg_wr_i = 1'b0;
    expect_reseed("R5 cfg");

    // R4 sweep every rate encoding
    for (int r = 0; r < 4; r++) begin
      int lim;
      lim = (r == 0) ? R0 : (r == 1) ? R1 : R2;
      cfg_rate_i = 2'(r);
      for (int k = 1; k <= lim; k++) begin
        blk_done_i = 1'b1; step(); blk_done_i = 1'b0;
        if (k < lim) chk($sformatf("R4 rate%0d blk%0d idle", r, k), idle_o, 1);
        else         expect_reseed($sformatf("R4 rate%0d hit", r));
      end
      // unrelated reseed restarts the count
      for (int k = 1; k < lim; k++) begin
        blk_done_i = 1'b1; step(); blk_done_i = 1'b0;
      end
      trig_reseed_i = 1'b1; step(); trig_reseed_i = 1'b0;
      expect_reseed("R4 mid reseed");
      for (int k = 1; k < lim; k++) begin
        blk_done_i = 1'b1; step(); blk_done_i = 1'b0;
      end
      chk($sformatf("R4 rate%0d restarted", r), idle_o, 1);
      blk_done_i = 1'b1; step(); blk_done_i = 1'b0;
      expect_reseed($sformatf("R4 rate%0d hit after restart", r));
    end

    // R6 wipe patterns
    for (int p = 1; p < 4; p++) begin
      trig_clr_in_i = p[0]; trig_clr_out_i = p[1];
      step();
      trig_clr_in_i = 1'b0; trig_clr_out_i = 1'b0;
      chk("R6 queued idle", idle_o, 0);
      chk("R7 queued in flag", trig_clr_in_o, p[0]);
      chk("R7 queued out flag", trig_clr_out_o, p[1]);
      step();
      chk("R7 wipe flags cleared", trig_clr_in_o | trig_clr_out_o, 0);
      run_wipe($sformatf("R6 pattern%0d", p), p[0], p[1]);
    end

    // R7 request raised while busy is held
    trig_reseed_i = 1'b1; step(); trig_reseed_i = 1'b0;
    step();
    chk("R7 busy req", ent_req_o, 1);
    trig_clr_out_i = 1'b1; step(); trig_clr_out_i = 1'b0;
    chk("R7 held flag", trig_clr_out_o, 1);
    chk("R7 no wipe during seed", clr_out_o, 0);
    serve_seed("R7 busy");
    chk("R7 pending keeps busy", idle_o, 0);
    step();
    run_wipe("R7 served", 1'b0, 1'b1);

    // R7 reseed before wipe
    trig_reseed_i = 1'b1; trig_clr_in_i = 1'b1; step();
    trig_reseed_i = 1'b0; trig_clr_in_i = 1'b0;
    step();
    chk("R7 order req first", ent_req_o, 1);
    chk("R7 order wipe waits", clr_in_o, 0);
    chk("R7 order wipe queued", trig_clr_in_o, 1);
    serve_seed("R7 order");
    step();
    run_wipe("R7 order wipe", 1'b1, 1'b0);

    // R8 terminal fault
    fault_i = 1'b1; step(); fault_i = 1'b0;
    chk("R8 alert", fatal_o, 1);
    chk("R8 release blocked", out_allow_o, 0);
    chk("R8 not idle", idle_o, 0);
    trig_reseed_i = 1'b1; trig_clr_in_i = 1'b1; step();
    trig_reseed_i = 1'b0; trig_clr_in_i = 1'b0;
    repeat (3) step();
    chk("R8 no req", ent_req_o, 0);
    chk("R8 no wipe", clr_in_o | clr_out_o, 0);
    chk("R8 sticky", fatal_o, 1);
    boot("R8 recover");

    summary();
    $finish;
  end
endmodule